// File: doc/BRIEF.md
# Lifecycle Transition Sequencer

This block steps a device through one requested lifecycle state change. It waits idle until a request arrives. It then takes over the clock source, checks the transition counter and programs it, checks that the requested transition is legal, and hashes the supplied token. An RMA-style request also runs a flash-erase handshake. The token comparison is done in two halves, one per state. The new lifecycle state is then programmed, and the sequencer parks in a post-transition state until the next reset. Each step that fails leaves early for the parked state and sets a sticky error bit.

Two independent escalation inputs override the sequence and drive the block into a terminal escalate state. A device that already carries a scrap condition is sent to a terminal scrap state instead of starting a transition. A malformed lifecycle decode sends it to an invalid state, which only escalation can leave. The state register uses a distance-3 code. A value that matches no legal code word is handled as escalation and raises a fatal alert. The clock mux, the OTP programmer, the hash engine and the flash controller sit outside the block. Each one is reached through a level request that stays high until that agent returns an acknowledge pulse, which may carry an error flag.

Top module: `lifecycle_step_seq`

## Requirements
- R1: While reset is held, `phase_o` reads 1 (Reset), all requests are low, and `err_o` and `fatal_alert_o` are 0. Once reset is released (two-flop synchronised release), the block enters Idle (`phase_o` = 2). The phase codes are: Reset 1, Idle 2, ClkMux 3, CntIncr 4, CntProg 5, TransCheck 6, TokenHash 7, FlashRma 8, TokenCheck0 9, TokenCheck1 10, TransProg 11, PostTrans 12, Scrap 13, Escalate 14, Invalid 15.
- R2: In Idle, `decode_fault_i` moves to Invalid. Otherwise a request with `scrap_cond_i` high moves to Scrap, and a plain request moves to ClkMux.
- R3: Each handshake request is high only in its own state, and at most one is high at a time. `clkmux_req_o` is high in ClkMux, `otp_req_o` in CntProg (`otp_op_o`=0) and in TransProg (`otp_op_o`=1), `hash_req_o` in TokenHash, and `flash_req_o` in FlashRma. A request stays high until its acknowledge arrives.
- R4: In CntIncr, `cnt_at_max_i` high exits to PostTrans and sets `err_o[0]` (counter overflow). Otherwise the next state is CntProg.
- R5: An OTP acknowledge with `otp_err_i` high, in CntProg or TransProg, exits to PostTrans and sets `err_o[1]` (programming failure). `err_o` bits never clear before reset.
- R6: In TransCheck, `trans_ok_i` low exits to PostTrans and sets `err_o[2]`. Otherwise the next state is TokenHash.
- R7: A hash acknowledge goes to FlashRma if the request captured `req_rma_i` high, and to TokenCheck0 if not. A hash acknowledge with its error flag high instead exits to PostTrans and sets `err_o[4]`.
- R8: TokenCheck0 passes to TokenCheck1 when `tok_lo_ok_i` is high. TokenCheck1 passes to TransProg when `tok_hi_ok_i` is high. A mismatch in either exits to PostTrans and sets `err_o[3]`. TokenCheck1 always leaves after one cycle.
- R9: A flash acknowledge always moves to TokenCheck0. If its error flag is high it sets `err_o[4]`, and TokenCheck0 then exits to PostTrans without setting `err_o[3]`.
- R10: A clean OTP acknowledge in TransProg moves to PostTrans. PostTrans ignores further requests.
- R11: Either escalation input forces Escalate from every state except Reset, Scrap and Escalate. Escalate and Scrap hold until reset.
- R12: `lc_en_o` is all zeros in Escalate and Scrap, and follows `en_req_i` in every other state.
- R13: A state register value that is no legal code word behaves as Escalate (`phase_o` = 14) and raises `fatal_alert_o`, which then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| esc0_i | input | 1 | Escalation input A |
| esc1_i | input | 1 | Escalation input B |
| req_valid_i | input | 1 | Transition request |
| req_rma_i | input | 1 | Request is RMA-style, captured with the request |
| scrap_cond_i | input | 1 | Device already in a scrap condition |
| decode_fault_i | input | 1 | Lifecycle state or counter decode is malformed |
| cnt_at_max_i | input | 1 | Transition counter is at its limit |
| trans_ok_i | input | 1 | Requested transition is legal |
| tok_lo_ok_i | input | 1 | Lower token half matches |
| tok_hi_ok_i | input | 1 | Upper token half matches |
| clkmux_req_o | output | 1 | Clock source switch request |
| clkmux_ack_i | input | 1 | Clock switch acknowledge |
| otp_req_o | output | 1 | OTP programming request |
| otp_op_o | output | 1 | 0 = counter write, 1 = state write |
| otp_ack_i | input | 1 | OTP acknowledge |
| otp_err_i | input | 1 | OTP error flag with acknowledge |
| hash_req_o | output | 1 | Token hash request |
| hash_ack_i | input | 1 | Hash acknowledge |
| hash_err_i | input | 1 | Hash error flag with acknowledge |
| flash_req_o | output | 1 | Flash erase request |
| flash_ack_i | input | 1 | Flash acknowledge |
| flash_err_i | input | 1 | Flash error flag with acknowledge |
| en_req_i | input | EN_W | Lifecycle enables requested by the decoder |
| lc_en_o | output | EN_W | Lifecycle enables after gating |
| phase_o | output | 4 | Current phase code |
| err_o | output | 5 | Sticky error bits |
| fatal_alert_o | output | 1 | Illegal state encoding seen |

## Verification
On every cycle the assertions check the following: the handshake requests are mutually exclusive, the clock request holds until its acknowledge, TokenCheck1 never repeats, PostTrans, Scrap and Escalate stay where they are, escalation always wins, the enables are gated off, and the error and fatal flags are sticky. The route a request takes can only be shown by the bench scenarios. These cover the RMA detour through FlashRma, the point where each error exits, which error bit each failure sets, and the Idle decisions for scrap and decode faults. The illegal-encoding case is also a bench scenario, and it needs the state register to be forced.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  localparam int ST_W  = 7;
  localparam int IDX_W = 4;
  localparam int ERR_W = 5;

  localparam int E_OVF   = 0;
  localparam int E_PROG  = 1;
  localparam int E_TRANS = 2;
  localparam int E_TOKEN = 3;
  localparam int E_AGENT = 4;

  typedef enum logic [IDX_W-1:0] {
    PH_RESET   = 4'd1,
    PH_IDLE    = 4'd2,
    PH_CLKMUX  = 4'd3,
    PH_CNTINC  = 4'd4,
    PH_CNTPRG  = 4'd5,
    PH_TCHECK  = 4'd6,
    PH_HASH    = 4'd7,
    PH_FLASH   = 4'd8,
    PH_TOK0    = 4'd9,
    PH_TOK1    = 4'd10,
    PH_TPROG   = 4'd11,
    PH_POST    = 4'd12,
    PH_SCRAP   = 4'd13,
    PH_ESC     = 4'd14,
    PH_INVALID = 4'd15
  } phase_e;

  // Distance-3 code word: four index bits followed by three parity bits.
  function automatic logic [ST_W-1:0] st_enc(input logic [IDX_W-1:0] d);
    logic p1, p2, p3;
    p1 = d[3] ^ d[2] ^ d[0];
    p2 = d[3] ^ d[1] ^ d[0];
    p3 = d[2] ^ d[1] ^ d[0];
    return {d, p1, p2, p3};
  endfunction
endpackage

// File: rtl/lcs_rst_sync.sv
module lcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/lcs_state_chk.sv
module lcs_state_chk
  import lcs_pkg::*;
(
  input  logic [ST_W-1:0] raw_i,
  output phase_e          phase_o,
  output logic            illegal_o
);
  localparam int N_CODES = 1 << IDX_W;

  always_comb begin
    phase_o   = PH_ESC;
    illegal_o = 1'b1;
    for (int i = 1; i < N_CODES; i++) begin
      if (raw_i == st_enc(IDX_W'(i))) begin
        phase_o   = phase_e'(IDX_W'(i));
        illegal_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/lcs_next_state.sv
module lcs_next_state
  import lcs_pkg::*;
(
  input  phase_e           cur_i,
  input  logic             esc_any_i,
  input  logic             req_valid_i,
  input  logic             scrap_cond_i,
  input  logic             decode_fault_i,
  input  logic             cnt_at_max_i,
  input  logic             trans_ok_i,
  input  logic             rma_i,
  input  logic             tok_lo_ok_i,
  input  logic             tok_hi_ok_i,
  input  logic             agent_failed_i,
  input  logic             clkmux_ack_i,
  input  logic             otp_ack_i,
  input  logic             otp_err_i,
  input  logic             hash_ack_i,
  input  logic             hash_err_i,
  input  logic             flash_ack_i,
  input  logic             flash_err_i,
  output phase_e           nxt_o,
  output logic [ERR_W-1:0] err_set_o
);
  logic esc_allowed;

  assign esc_allowed = (cur_i != PH_RESET) && (cur_i != PH_SCRAP) && (cur_i != PH_ESC);

  always_comb begin
    nxt_o     = cur_i;
    err_set_o = '0;
    if (esc_any_i && esc_allowed) begin
      nxt_o = PH_ESC;
    end else begin
      unique case (cur_i)
        PH_RESET:  nxt_o = PH_IDLE;
        PH_IDLE: begin
          if (decode_fault_i)                   nxt_o = PH_INVALID;
          else if (req_valid_i && scrap_cond_i) nxt_o = PH_SCRAP;
          else if (req_valid_i)                 nxt_o = PH_CLKMUX;
        end
        PH_CLKMUX: if (clkmux_ack_i) nxt_o = PH_CNTINC;
        PH_CNTINC: begin
          if (cnt_at_max_i) begin
            nxt_o            = PH_POST;
            err_set_o[E_OVF] = 1'b1;
          end else begin
            nxt_o = PH_CNTPRG;
          end
        end
        PH_CNTPRG: begin
          if (otp_ack_i && otp_err_i) begin
            nxt_o             = PH_POST;
            err_set_o[E_PROG] = 1'b1;
          end else if (otp_ack_i) begin
            nxt_o = PH_TCHECK;
          end
        end
        PH_TCHECK: begin
          if (!trans_ok_i) begin
            nxt_o              = PH_POST;
            err_set_o[E_TRANS] = 1'b1;
          end else begin
            nxt_o = PH_HASH;
          end
        end
        PH_HASH: begin
          if (hash_ack_i && hash_err_i) begin
            nxt_o              = PH_POST;
            err_set_o[E_AGENT] = 1'b1;
          end else if (hash_ack_i) begin
            nxt_o = rma_i ? PH_FLASH : PH_TOK0;
          end
        end
        PH_FLASH: begin
          if (flash_ack_i) begin
            nxt_o              = PH_TOK0;
            err_set_o[E_AGENT] = flash_err_i;
          end
        end
        PH_TOK0: begin
          if (agent_failed_i) begin
            nxt_o = PH_POST;
          end else if (!tok_lo_ok_i) begin
            nxt_o              = PH_POST;
            err_set_o[E_TOKEN] = 1'b1;
          end else begin
            nxt_o = PH_TOK1;
          end
        end
        PH_TOK1: begin
          if (tok_hi_ok_i) begin
            nxt_o = PH_TPROG;
          end else begin
            nxt_o              = PH_POST;
            err_set_o[E_TOKEN] = 1'b1;
          end
        end
        PH_TPROG: begin
          if (otp_ack_i) begin
            nxt_o             = PH_POST;
            err_set_o[E_PROG] = otp_err_i;
          end
        end
        PH_POST, PH_SCRAP, PH_ESC, PH_INVALID: nxt_o = cur_i;
        default: nxt_o = PH_ESC;
      endcase
    end
  end
endmodule

// File: rtl/lcs_err_track.sv
module lcs_err_track #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] err_o
);
  logic [W-1:0] err_q;
  logic         upd_en;

  assign upd_en = |set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     err_q <= '0;
    else if (upd_en) err_q <= err_q | set_i;
  end

  assign err_o = err_q;
endmodule

// File: rtl/lifecycle_step_seq.sv
module lifecycle_step_seq
  import lcs_pkg::*;
#(
  parameter int EN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             esc0_i,
  input  logic             esc1_i,
  input  logic             req_valid_i,
  input  logic             req_rma_i,
  input  logic             scrap_cond_i,
  input  logic             decode_fault_i,
  input  logic             cnt_at_max_i,
  input  logic             trans_ok_i,
  input  logic             tok_lo_ok_i,
  input  logic             tok_hi_ok_i,
  output logic             clkmux_req_o,
  input  logic             clkmux_ack_i,
  output logic             otp_req_o,
  output logic             otp_op_o,
  input  logic             otp_ack_i,
  input  logic             otp_err_i,
  output logic             hash_req_o,
  input  logic             hash_ack_i,
  input  logic             hash_err_i,
  output logic             flash_req_o,
  input  logic             flash_ack_i,
  input  logic             flash_err_i,
  input  logic [EN_W-1:0]  en_req_i,
  output logic [EN_W-1:0]  lc_en_o,
  output logic [3:0]       phase_o,
  output logic [ERR_W-1:0] err_o,
  output logic             fatal_alert_o
);
  logic             rst_n_s;
  logic [ST_W-1:0]  state_q, state_d;
  phase_e           cur, nxt;
  logic             illegal;
  logic             rma_q, rma_en;
  logic             fatal_q;
  logic [ERR_W-1:0] err_set;
  logic [ERR_W-1:0] err_q;
  logic             esc_any;

  lcs_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_s)
  );

  lcs_state_chk u_state_chk (
    .raw_i     (state_q),
    .phase_o   (cur),
    .illegal_o (illegal)
  );

  assign esc_any = esc0_i | esc1_i;

  lcs_next_state u_next (
    .cur_i          (cur),
    .esc_any_i      (esc_any),
    .req_valid_i    (req_valid_i),
    .scrap_cond_i   (scrap_cond_i),
    .decode_fault_i (decode_fault_i),
    .cnt_at_max_i   (cnt_at_max_i),
    .trans_ok_i     (trans_ok_i),
    .rma_i          (rma_q),
    .tok_lo_ok_i    (tok_lo_ok_i),
    .tok_hi_ok_i    (tok_hi_ok_i),
    .agent_failed_i (err_q[E_AGENT]),
    .clkmux_ack_i   (clkmux_ack_i),
    .otp_ack_i      (otp_ack_i),
    .otp_err_i      (otp_err_i),
    .hash_ack_i     (hash_ack_i),
    .hash_err_i     (hash_err_i),
    .flash_ack_i    (flash_ack_i),
    .flash_err_i    (flash_err_i),
    .nxt_o          (nxt),
    .err_set_o      (err_set)
  );

  lcs_err_track #(.W(ERR_W)) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .set_i  (err_set),
    .err_o  (err_q)
  );

  assign state_d = st_enc(nxt);

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) state_q <= st_enc(PH_RESET);
    else          state_q <= state_d;
  end

  assign rma_en = (cur == PH_IDLE) && req_valid_i;

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s)    rma_q <= 1'b0;
    else if (rma_en) rma_q <= req_rma_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s)     fatal_q <= 1'b0;
    else if (illegal) fatal_q <= 1'b1;
  end

  assign clkmux_req_o  = (cur == PH_CLKMUX);
  assign otp_req_o     = (cur == PH_CNTPRG) || (cur == PH_TPROG);
  assign otp_op_o      = (cur == PH_TPROG);
  assign hash_req_o    = (cur == PH_HASH);
  assign flash_req_o   = (cur == PH_FLASH);
  assign lc_en_o       = ((cur == PH_ESC) || (cur == PH_SCRAP)) ? '0 : en_req_i;
  assign phase_o       = cur;
  assign err_o         = err_q;
  assign fatal_alert_o = fatal_q | illegal;
endmodule

// File: rtl/lifecycle_step_seq_chk.sv
module lifecycle_step_seq_chk #(
  parameter int EN_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            esc0_i,
  input logic            esc1_i,
  input logic            clkmux_req_o,
  input logic            clkmux_ack_i,
  input logic            otp_req_o,
  input logic            hash_req_o,
  input logic            flash_req_o,
  input logic [EN_W-1:0] lc_en_o,
  input logic [3:0]      phase_o,
  input logic [4:0]      err_o,
  input logic            fatal_alert_o
);
  a_r3_req_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({clkmux_req_o, otp_req_o, hash_req_o, flash_req_o}));

  a_r3_clk_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clkmux_req_o && !clkmux_ack_i && !esc0_i && !esc1_i) |=> clkmux_req_o);

  a_r5_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((err_o & $past(err_o)) == $past(err_o)));

  a_r8_tok1_leaves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 4'd10) |=> (phase_o != 4'd10));

  a_r10_post_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 4'd12 && !esc0_i && !esc1_i) |=> (phase_o == 4'd12));

  a_r11_esc_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((esc0_i || esc1_i) && phase_o != 4'd1 && phase_o != 4'd13) |=> (phase_o == 4'd14));

  a_r11_esc_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 4'd14) |=> (phase_o == 4'd14));

  a_r11_scrap_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 4'd13) |=> (phase_o == 4'd13));

  a_r12_en_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 4'd13 || phase_o == 4'd14) |-> (lc_en_o == '0));

  a_r13_fatal_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_alert_o |=> fatal_alert_o);
endmodule

bind lifecycle_step_seq lifecycle_step_seq_chk #(.EN_W(EN_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .esc0_i        (esc0_i),
  .esc1_i        (esc1_i),
  .clkmux_req_o  (clkmux_req_o),
  .clkmux_ack_i  (clkmux_ack_i),
  .otp_req_o     (otp_req_o),
  .hash_req_o    (hash_req_o),
  .flash_req_o   (flash_req_o),
  .lc_en_o       (lc_en_o),
  .phase_o       (phase_o),
  .err_o         (err_o),
  .fatal_alert_o (fatal_alert_o)
);

// File: tb/lifecycle_step_seq_tb.sv
module lifecycle_step_seq_tb;
  localparam int EN_W = 4;
  localparam int NV   = 10;

  // {rma, cmax, tbad, lobad, hibad, cnterr, hasherr, flasherr, progerr,
  //  exp_err[4:0], exp_flash_seen, exp_tprog_seen}
  localparam logic [15:0] VEC [NV] = '{
    16'b0000_0000_0000_0001,  // plain transition, clean
    16'b1000_0000_0000_0011,  // RMA transition, clean
    16'b0100_0000_0000_0100,  // counter at limit
    16'b0000_0100_0000_1000,  // counter program error
    16'b0010_0000_0001_0000,  // illegal transition
    16'b0000_0010_0100_0000,  // hash error
    16'b0001_0000_0010_0000,  // low half mismatch
    16'b0000_1000_0010_0000,  // high half mismatch
    16'b1000_0001_0100_0010,  // RMA with flash error
    16'b0000_0000_1000_1001   // state program error
  };

  logic clk_i = 1'b0;
  logic rst_ni;
  logic esc0_i, esc1_i, req_valid_i, req_rma_i, scrap_cond_i, decode_fault_i;
  logic cnt_at_max_i, trans_ok_i, tok_lo_ok_i, tok_hi_ok_i;
  logic clkmux_req_o, clkmux_ack_i, otp_req_o, otp_op_o, otp_ack_i, otp_err_i;
  logic hash_req_o, hash_ack_i, hash_err_i, flash_req_o, flash_ack_i, flash_err_i;
  logic [EN_W-1:0] en_req_i, lc_en_o;
  logic [3:0] phase_o;
  logic [4:0] err_o;
  logic fatal_alert_o;

  logic v_cnterr, v_progerr, v_hasherr, v_flasherr;
  logic hold_clk;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #10 clk_i = ~clk_i;

  lifecycle_step_seq #(.EN_W(EN_W)) u_dut (.*);

  assign otp_err_i   = otp_op_o ? v_progerr : v_cnterr;
  assign hash_err_i  = v_hasherr;
  assign flash_err_i = v_flasherr;

  // Agent responders: acknowledge one cycle after seeing a request.
  always @(negedge clk_i) begin
    clkmux_ack_i <= clkmux_req_o && !hold_clk;
    otp_ack_i    <= otp_req_o;
    hash_ack_i   <= hash_req_o;
    flash_ack_i  <= flash_req_o;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic pulse_req();
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    rst_ni = 1'b0;
    {esc0_i, esc1_i, req_valid_i, req_rma_i, scrap_cond_i, decode_fault_i} = '0;
    cnt_at_max_i = 1'b0; trans_ok_i = 1'b1; tok_lo_ok_i = 1'b1; tok_hi_ok_i = 1'b1;
    {v_cnterr, v_progerr, v_hasherr, v_flasherr} = '0;
    hold_clk = 1'b0;
    en_req_i = 4'hA;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(phase_o == 4'd1, "R1 reset phase", phase_o, 1);
    chk({clkmux_req_o, otp_req_o, hash_req_o, flash_req_o} == 4'b0, "R1 requests low",
        {clkmux_req_o, otp_req_o, hash_req_o, flash_req_o}, 0);
    chk(err_o == 5'd0 && !fatal_alert_o, "R1 flags clear", {fatal_alert_o, err_o}, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(phase_o == 4'd2, "R1 idle after reset", phase_o, 2);
    chk(lc_en_o == 4'hA, "R12 enables follow in idle", lc_en_o, 'hA);

    // Vector table: full transitions with responders
    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      bit fl_seen, tp_seen;
      v = VEC[i];
      req_rma_i    = v[15];
      cnt_at_max_i = v[14];
      trans_ok_i   = !v[13];
      tok_lo_ok_i  = !v[12];
      tok_hi_ok_i  = !v[11];
      v_cnterr     = v[10];
      v_hasherr    = v[9];
      v_flasherr   = v[8];
      v_progerr    = v[7];
      do_reset();
      pulse_req();
      chk(phase_o == 4'd3 && clkmux_req_o, "R2 R3 request enters clock switch", phase_o, 3);
      fl_seen = 1'b0;
      tp_seen = 1'b0;
      for (int c = 0; c < 60 && phase_o != 4'd12; c++) begin
        if (phase_o == 4'd8) fl_seen = 1'b1;
        if (phase_o == 4'd11) tp_seen = 1'b1;
        @(negedge clk_i);
      end
      chk(phase_o == 4'd12, "R10 parked in post-transition", phase_o, 12);
      chk(err_o == v[6:2], "R4 R5 R6 R7 R8 R9 error bits", err_o, v[6:2]);
      chk(fl_seen == v[1], "R7 R9 flash erase visited", fl_seen, v[1]);
      chk(tp_seen == v[0], "R8 R10 state programming visited", tp_seen, v[0]);
    end

    // R10 post-transition ignores a new request, R11 escalation from it
    pulse_req();
    repeat (2) @(negedge clk_i);
    chk(phase_o == 4'd12, "R10 post-transition ignores request", phase_o, 12);
    esc0_i = 1'b1;
    @(negedge clk_i);
    esc0_i = 1'b0;
    chk(phase_o == 4'd14, "R11 escalate from post-transition", phase_o, 14);
    chk(lc_en_o == 4'h0, "R12 enables off in escalate", lc_en_o, 0);
    {v_cnterr, v_hasherr, v_flasherr, v_progerr} = '0;
    req_rma_i = 1'b0; cnt_at_max_i = 1'b0; trans_ok_i = 1'b1;
    tok_lo_ok_i = 1'b1; tok_hi_ok_i = 1'b1;

    // R2 scrap condition, R11 scrap terminal, R12 enables off
    do_reset();
    en_req_i = 4'hF;
    scrap_cond_i = 1'b1;
    pulse_req();
    scrap_cond_i = 1'b0;
    chk(phase_o == 4'd13, "R2 scrap condition", phase_o, 13);
    chk(lc_en_o == 4'h0, "R12 enables off in scrap", lc_en_o, 0);
    pulse_req();
    esc1_i = 1'b1;
    @(negedge clk_i);
    esc1_i = 1'b0;
    @(negedge clk_i);
    chk(phase_o == 4'd13, "R11 scrap holds", phase_o, 13);

    // R2 decode fault to invalid, R11 escalation from invalid
    do_reset();
    decode_fault_i = 1'b1;
    @(negedge clk_i);
    decode_fault_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(phase_o == 4'd15, "R2 decode fault to invalid", phase_o, 15);
    chk(lc_en_o == 4'hF, "R12 enables follow in invalid", lc_en_o, 'hF);
    esc0_i = 1'b1;
    @(negedge clk_i);
    esc0_i = 1'b0;
    chk(phase_o == 4'd14, "R11 escalate from invalid", phase_o, 14);

    // R3 request held without acknowledge, R11 escalation mid-handshake
    do_reset();
    hold_clk = 1'b1;
    pulse_req();
    repeat (3) @(negedge clk_i);
    chk(phase_o == 4'd3 && clkmux_req_o, "R3 clock request held", phase_o, 3);
    esc1_i = 1'b1;
    @(negedge clk_i);
    esc1_i = 1'b0;
    hold_clk = 1'b0;
    chk(phase_o == 4'd14 && !clkmux_req_o, "R11 escalate mid handshake", phase_o, 14);
    repeat (3) @(negedge clk_i);
    chk(phase_o == 4'd14, "R11 escalate holds", phase_o, 14);

    // R13 illegal encoding injected into the state register
    do_reset();
    force u_dut.state_q = 7'b0000001;
    @(negedge clk_i);
    chk(phase_o == 4'd14 && fatal_alert_o, "R13 illegal code as escalate", phase_o, 14);
    release u_dut.state_q;
    repeat (2) @(negedge clk_i);
    chk(phase_o == 4'd14, "R13 settles in escalate", phase_o, 14);
    chk(fatal_alert_o == 1'b1, "R13 fatal alert sticky", fatal_alert_o, 1);

    finish_up();
  end
endmodule